// File: doc/BRIEF.md
# Segmented address relocation unit

This block turns a virtual address into a physical address through a four-entry segment map. The two highest address bits pick a segment and the remaining thirty bits are the offset inside it. Each segment has a base, a bound and a read-only flag. The offset is compared against the bound while the base is being added to it. A reference outside the bound, or a write to a read-only segment, returns a fault code instead of an address.

The map and a relocation-enable bit are loaded through a small configuration write port. That port accepts writes only while the privilege input says kernel mode. A write attempted in user mode changes nothing and raises a one-cycle privilege-error pulse. While relocation is disabled, addresses pass straight through, so privileged code can reach all of memory. Every translation result appears on registered outputs one cycle after the request.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset, rsp_valid_o, rsp_paddr_o, rsp_fault_o and priv_err_o are all 0. Relocation is disabled, and every segment has base 0, bound 0 and the read-write setting.
- R2: While relocation is disabled, a request returns rsp_paddr_o equal to req_addr_i and fault code 2'b00, whatever the segment settings and the write flag.
- R3: With relocation enabled, req_addr_i[31:30] selects the segment and req_addr_i[29:0] is the offset, zero-extended to 32 bits.
- R4: With relocation enabled and the offset below the selected bound, and no write-protect fault, rsp_paddr_o is base + offset modulo 2^32 and the fault code is 2'b00.
- R5: An offset greater than or equal to the selected bound gives fault code 2'b01 and rsp_paddr_o = 0. A bound of 0 therefore faults every reference to that segment. The bound fault takes priority over the write-protect fault.
- R6: A write request (req_write_i = 1) inside the bound of a read-only segment gives fault code 2'b10 and rsp_paddr_o = 0. Read requests to that segment translate normally.
- R7: Results appear one cycle after the request: rsp_valid_o equals req_valid_i of the previous cycle. In a cycle where rsp_valid_o is 0, rsp_paddr_o and rsp_fault_o are 0.
- R8: A configuration write with kernel_i = 1 selects its target with cfg_field_i. Code 0 writes the base of segment cfg_seg_i. Code 1 writes that segment's bound. Code 2 sets its read-only flag from cfg_wdata_i[0]. Code 3 sets relocation enable from cfg_wdata_i[0], and cfg_seg_i is ignored. A request issued in the same cycle as a write uses the old contents; the next request uses the new contents.
- R9: A configuration write with kernel_i = 0 leaves the map and the relocation-enable bit unchanged. It drives priv_err_o to 1 in the following cycle only.
- R10: priv_err_o is 0 in any cycle that does not follow a user-mode configuration write. Kernel-mode writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kernel_i | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_field_i | input | 2 | Target: 0 base, 1 bound, 2 read-only, 3 relocation enable |
| cfg_seg_i | input | 2 | Segment addressed by the write |
| cfg_wdata_i | input | 32 | Write data |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = store access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 00 none, 01 bound, 10 write-protect |
| priv_err_o | output | 1 | One-cycle pulse after a refused user-mode write |

## Verification
Translation results and priv_err_o both come from one register stage. Each is therefore due at the first rising edge after the stimulus is applied. The bench drives inputs on a falling edge and samples one full period later, on the next falling edge. A configuration write takes effect for the request driven in the cycle after the write. The bench therefore issues a request in the same cycle as a write to check the old contents, then issues one in the next cycle to check the new contents. It checks that priv_err_o returns low one cycle after it pulses.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_BOUND = 2'b01,
    FLT_WPROT = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_BOUND = 2'd1,
    FLD_PROT  = 2'd2,
    FLD_MODE  = 2'd3
  } cfg_fld_e;
endpackage

// File: rtl/seg_map_regs.sv
module seg_map_regs #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 2,
  localparam int NUM_SEG = 1 << SEG_BITS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             kernel_i,
  input  logic                             we_i,
  input  logic [1:0]                       field_i,
  input  logic [SEG_BITS-1:0]              seg_i,
  input  logic [ADDR_W-1:0]                wdata_i,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]   base_o,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]   bound_o,
  output logic [NUM_SEG-1:0]               ro_o,
  output logic                             reloc_en_o,
  output logic                             priv_err_o
);
  import seg_reloc_pkg::*;

  logic     wr_ok;
  logic     wr_bad;
  cfg_fld_e fld;

  assign fld    = cfg_fld_e'(field_i);
  assign wr_ok  = we_i & kernel_i;
  assign wr_bad = we_i & ~kernel_i;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic hit;
    assign hit = wr_ok && (seg_i == SEG_BITS'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[s]  <= '0;
        bound_o[s] <= '0;
        ro_o[s]    <= 1'b0;
      end else if (hit) begin
        case (fld)
          FLD_BASE:  base_o[s]  <= wdata_i;
          FLD_BOUND: bound_o[s] <= wdata_i;
          FLD_PROT:  ro_o[s]    <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reloc_en_o <= 1'b0;
      priv_err_o <= 1'b0;
    end else begin
      priv_err_o <= wr_bad;
      if (wr_ok && fld == FLD_MODE) reloc_en_o <= wdata_i[0];
    end
  end

  // R9
  user_wr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad |=> $stable(reloc_en_o) && $stable(base_o) && $stable(bound_o) && $stable(ro_o));

  // R10
  kernel_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kernel_i) |=> !priv_err_o);

  // R9
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_err_o |-> $past(we_i) && !$past(kernel_i));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 2,
  localparam int NUM_SEG = 1 << SEG_BITS,
  localparam int OFF_W   = ADDR_W - SEG_BITS
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             write_i,
  input  logic                             reloc_en_i,
  input  logic [NUM_SEG-1:0][ADDR_W-1:0]   base_i,
  input  logic [NUM_SEG-1:0][ADDR_W-1:0]   bound_i,
  input  logic [NUM_SEG-1:0]               ro_i,
  output logic [ADDR_W-1:0]                paddr_o,
  output seg_reloc_pkg::fault_e            fault_o
);
  import seg_reloc_pkg::*;

  logic [SEG_BITS-1:0] seg;
  logic [ADDR_W-1:0]   off;
  logic [ADDR_W-1:0]   sum;
  logic                over;
  logic                wprot;

  assign seg   = addr_i[ADDR_W-1 -: SEG_BITS];
  assign off   = {{SEG_BITS{1'b0}}, addr_i[OFF_W-1:0]};
  // adder and comparator work side by side; the fault selects which survives
  assign sum   = base_i[seg] + off;
  assign over  = off >= bound_i[seg];
  assign wprot = write_i & ro_i[seg];

  always_comb begin
    paddr_o = '0;
    fault_o = FLT_NONE;
    if (!reloc_en_i) begin
      paddr_o = addr_i;
    end else if (over) begin
      fault_o = FLT_BOUND;
    end else if (wprot) begin
      fault_o = FLT_WPROT;
    end else begin
      paddr_o = sum;
    end
  end
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int ADDR_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [ADDR_W-1:0]     paddr_i,
  input  seg_reloc_pkg::fault_e fault_i,
  output logic                  valid_o,
  output logic [ADDR_W-1:0]     paddr_o,
  output logic [1:0]            fault_o
);
  import seg_reloc_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      paddr_o <= '0;
      fault_o <= FLT_NONE;
    end else begin
      valid_o <= valid_i;
      paddr_o <= valid_i ? paddr_i : '0;
      fault_o <= valid_i ? fault_i : FLT_NONE;
    end
  end

  // R5
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o != 2'b00) |-> (paddr_o == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (paddr_o == '0) && (fault_o == 2'b00));

  // R6
  fault_code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o != 2'b11);
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                kernel_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_field_i,
  input  logic [SEG_BITS-1:0] cfg_seg_i,
  input  logic [ADDR_W-1:0]   cfg_wdata_i,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_write_i,
  output logic                rsp_valid_o,
  output logic [ADDR_W-1:0]   rsp_paddr_o,
  output logic [1:0]          rsp_fault_o,
  output logic                priv_err_o
);
  import seg_reloc_pkg::*;

  localparam int NUM_SEG = 1 << SEG_BITS;

  logic [NUM_SEG-1:0][ADDR_W-1:0] base;
  logic [NUM_SEG-1:0][ADDR_W-1:0] bound;
  logic [NUM_SEG-1:0]             ro;
  logic                           reloc_en;
  logic [ADDR_W-1:0]              xl_paddr;
  fault_e                         xl_fault;

  seg_map_regs #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kernel_i   (kernel_i),
    .we_i       (cfg_we_i),
    .field_i    (cfg_field_i),
    .seg_i      (cfg_seg_i),
    .wdata_i    (cfg_wdata_i),
    .base_o     (base),
    .bound_o    (bound),
    .ro_o       (ro),
    .reloc_en_o (reloc_en),
    .priv_err_o (priv_err_o)
  );

  seg_xlate #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_xlate (
    .addr_i     (req_addr_i),
    .write_i    (req_write_i),
    .reloc_en_i (reloc_en),
    .base_i     (base),
    .bound_i    (bound),
    .ro_i       (ro),
    .paddr_o    (xl_paddr),
    .fault_o    (xl_fault)
  );

  seg_rsp_reg #(.ADDR_W(ADDR_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .paddr_i (xl_paddr),
    .fault_i (xl_fault),
    .valid_o (rsp_valid_o),
    .paddr_o (rsp_paddr_o),
    .fault_o (rsp_fault_o)
  );

  // R2
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !reloc_en) |=>
      (rsp_paddr_o == $past(req_addr_i)) && (rsp_fault_o == 2'b00));

  // R7
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
endmodule

// File: tb/seg_reloc_unit_tb_top.sv
module seg_reloc_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;
  localparam int  NVEC       = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernel = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_field = '0;
  logic [1:0]  cfg_seg = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        priv_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_reloc_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .kernel_i    (kernel),
    .cfg_we_i    (cfg_we),
    .cfg_field_i (cfg_field),
    .cfg_seg_i   (cfg_seg),
    .cfg_wdata_i (cfg_wdata),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .req_write_i (req_write),
    .rsp_valid_o (rsp_valid),
    .rsp_paddr_o (rsp_paddr),
    .rsp_fault_o (rsp_fault),
    .priv_err_o  (priv_err)
  );

  // {vaddr, write, expected paddr, expected fault}
  localparam logic [66:0] VEC [NVEC] = '{
    {32'h0000_0000, 1'b0, 32'h1000_0000, 2'b00},  // R3 R4 seg0
    {32'h0000_00FF, 1'b1, 32'h1000_00FF, 2'b00},  // R4 last legal offset
    {32'h0000_0100, 1'b0, 32'h0000_0000, 2'b01},  // R5 offset == bound
    {32'h4000_0000, 1'b0, 32'h8000_0000, 2'b00},  // R3 seg1 read
    {32'h4000_0004, 1'b1, 32'h0000_0000, 2'b10},  // R6 write to read-only
    {32'h6FFF_FFFF, 1'b0, 32'hAFFF_FFFF, 2'b00},  // R4
    {32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 2'b01},  // R5 bound beats protect
    {32'h8000_1000, 1'b0, 32'h0000_0000, 2'b00},  // R4 wrap mod 2^32
    {32'h8000_1FFF, 1'b1, 32'h0000_0FFF, 2'b00},  // R4
    {32'h8000_2000, 1'b1, 32'h0000_0000, 2'b01},  // R5
    {32'hC000_0000, 1'b0, 32'h0000_0000, 2'b01},  // R5 zero bound
    {32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 2'b01}   // R5 zero bound
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic k, input logic [1:0] f, input logic [1:0] s,
                        input logic [31:0] d);
    @(negedge clk);
    kernel = k; cfg_we = 1'b1; cfg_field = f; cfg_seg = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; kernel = 1'b1;
  endtask

  task automatic xlate(input logic [31:0] a, input logic w,
                       input logic [31:0] ep, input logic [1:0] ef, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'(1'b1));
    chk({req, " paddr"}, 64'(rsp_paddr), 64'(ep));
    chk({req, " fault"}, 64'(rsp_fault), 64'(ef));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(rsp_valid), 0);
    chk("R1 paddr", 64'(rsp_paddr), 0);
    chk("R1 fault", 64'(rsp_fault), 0);
    chk("R1 priv_err", 64'(priv_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 relocation off after reset; R2 passthrough even for writes
    xlate(32'hC000_0123, 1'b1, 32'hC000_0123, 2'b00, "R1 R2 bypass");

    // R8 kernel-mode configuration
    cfg_wr(1, 2'd0, 2'd0, 32'h1000_0000);
    cfg_wr(1, 2'd1, 2'd0, 32'h0000_0100);
    cfg_wr(1, 2'd0, 2'd1, 32'h8000_0000);
    cfg_wr(1, 2'd1, 2'd1, 32'h3000_0000);
    cfg_wr(1, 2'd2, 2'd1, 32'h1);
    cfg_wr(1, 2'd0, 2'd2, 32'hFFFF_F000);
    cfg_wr(1, 2'd1, 2'd2, 32'h0000_2000);
    chk("R10 kernel writes", 64'(priv_err), 0);
    // R2 map loaded but relocation still off
    xlate(32'h4000_0004, 1'b1, 32'h4000_0004, 2'b00, "R2 bypass loaded");
    cfg_wr(1, 2'd3, 2'd2, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      xlate(VEC[i][66:35], VEC[i][34], VEC[i][33:2], VEC[i][1:0], "R3-vector");
    end

    // R7 idle cycle: no valid, outputs zero
    @(negedge clk);
    chk("R7 idle valid", 64'(rsp_valid), 0);
    chk("R7 idle paddr", 64'(rsp_paddr), 0);

    // R9 user-mode write refused, one-cycle pulse
    @(negedge clk);
    kernel = 1'b0; cfg_we = 1'b1; cfg_field = 2'd0; cfg_seg = 2'd0; cfg_wdata = 32'h2222_0000;
    @(negedge clk);
    cfg_we = 1'b0; kernel = 1'b1;
    chk("R9 priv_err pulse", 64'(priv_err), 1);
    @(negedge clk);
    chk("R9 R10 pulse ends", 64'(priv_err), 0);
    xlate(32'h0000_0010, 1'b0, 32'h1000_0010, 2'b00, "R9 base unchanged");
    cfg_wr(0, 2'd3, 2'd0, 32'h0);
    xlate(32'h0000_0010, 1'b0, 32'h1000_0010, 2'b00, "R9 enable unchanged");
    cfg_wr(0, 2'd2, 2'd1, 32'h0);
    xlate(32'h4000_0004, 1'b1, 32'h0000_0000, 2'b10, "R9 protect unchanged");

    // R8 request in same cycle as write sees old map, next sees new
    @(negedge clk);
    cfg_we = 1'b1; cfg_field = 2'd0; cfg_seg = 2'd0; cfg_wdata = 32'h5000_0000;
    req_valid = 1'b1; req_addr = 32'h0000_0004; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 old base", 64'(rsp_paddr), 64'(32'h1000_0004));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 new base", 64'(rsp_paddr), 64'(32'h5000_0004));

    // R8 clearing read-only flag; R6 read of read-only segment ok earlier
    cfg_wr(1, 2'd2, 2'd1, 32'h0);
    xlate(32'h4000_0004, 1'b1, 32'h8000_0004, 2'b00, "R8 protect cleared");

    // R8 mode field disables relocation; R2 passthrough
    cfg_wr(1, 2'd3, 2'd1, 32'h0);
    xlate(32'h8000_2000, 1'b1, 32'h8000_2000, 2'b00, "R8 R2 disabled");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule